// File: doc/BRIEF.md
# Reset Vector Jump Sequencer

This block makes a processor start at a chosen address after a clear. When a clear request arrives and the feature is enabled, the block takes over the data bus in place of memory. It supplies a fixed four-byte instruction stream, one byte per read strobe. The stream disables interrupts, then jumps to the address whose high byte comes from an 8-bit setting and whose low byte is zero. The target can therefore be any 256-byte boundary from 0000 to FF00 hex.

The clear can come from either of two active-low sources, the power-on clear or the bus reset. A configuration bit picks which one is used, and the chosen request is synchronised to the clock. The fifth step releases the data drivers. During all five steps a busy flag keeps the ROM decoder off the bus. During the four byte steps a phantom request keeps the other memory boards silent. The next read strobe after the fifth step returns the block to idle.

Top module: `vecjump_seq`

## Requirements
- R1: After synchronous reset (rst_n low), jump_active, phantom_req and dout_oe are all 0.
- R2: When clr_src_sel is 0, the clear source is por_clr_n. When it is 1, the source is bus_rst_n. The source that is not selected has no effect on any output.
- R3: With jump_en at 1, a low level on the selected clear source puts the block at step one (jump_active=1, phantom_req=1) no later than the third rising clock edge after the low level. Step one holds while the clear stays low. A new clear during a sequence restarts it at step one.
- R4: The bytes on dout at steps one to four are F3 hex, C3 hex, 00 hex, then tgt_hi, in that order. Bit i of tgt_hi (1 = switch on) becomes jump address bit 8+i.
- R5: The block advances one step on each high-to-low transition of rd_strobe seen at a clock edge. It does not advance while rd_strobe is held high or held low.
- R6: dout_oe is 1 only during steps one to four while rd_strobe is 1. dout is 00 hex at every other step.
- R7: Step five follows the fourth read. In step five, dout_oe stays 0 even when rd_strobe is high, and jump_active stays 1. The next strobe fall returns the block to idle with jump_active at 0.
- R8: jump_active is 1 in all five steps and 0 when idle.
- R9: phantom_req is 1 in steps one to four and 0 in step five and when idle.
- R10: With jump_en at 0, no clear starts a sequence. When jump_en drops during a sequence, jump_active is 0 after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| por_clr_n | input | 1 | Power-on clear request, active low |
| bus_rst_n | input | 1 | Bus reset request, active low |
| clr_src_sel | input | 1 | Clear source select: 0 power-on, 1 bus reset |
| jump_en | input | 1 | Feature enable; 0 suppresses the sequence |
| tgt_hi | input | 8 | High byte of the jump target |
| rd_strobe | input | 1 | Bus read strobe, high during a read |
| dout | output | 8 | Injected instruction byte |
| dout_oe | output | 1 | Drive enable for dout |
| jump_active | output | 1 | Sequence running; blocks the ROM decoder |
| phantom_req | output | 1 | Silences other memory boards |

## Verification
Several properties are checked on every cycle. The drive enable may rise only with the strobe high and the phantom request set. Any driven byte must be one of the three fixed opcodes or the target byte. The phantom request must never appear without the busy flag. Clearing the enable must idle the block on the next edge. Leaving a sequence through its normal path must pass through a step with the phantom request off. Only the bench scenarios can show the full byte order for a given target and the advance on strobe falls alone. They also cover the latency of the clear synchroniser, the choice between the two clear sources, and a restart in the middle of a sequence.

// File: rtl/vj_pkg.sv
// Package: shared step encoding and fixed opcode bytes for the vector
// jump sequencer. Assumes an 8-bit data path.
package vj_pkg;
    localparam int DATA_W = 8;

    localparam logic [DATA_W-1:0] OP_DI  = 8'hF3;
    localparam logic [DATA_W-1:0] OP_JMP = 8'hC3;
    localparam logic [DATA_W-1:0] OP_LO  = 8'h00;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_DI   = 3'd1,
        ST_JMP  = 3'd2,
        ST_LO   = 3'd3,
        ST_HI   = 3'd4,
        ST_REL  = 3'd5
    } vj_step_e;
endpackage

// File: rtl/vj_clr_sync.sv
// Module: picks one of two active-low clear requests and brings it into
// the clock domain through a flop chain. Assumes the requests are
// asynchronous and last longer than SYNC_STAGES clocks.
module vj_clr_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic por_clr_n,
    input  logic bus_rst_n,
    input  logic clr_src_sel,
    output logic clr_act
);
    localparam int LAST = SYNC_STAGES - 1;

    logic             req_n;
    logic [LAST:0]    chain;

    // Select the configured clear source.
    always_comb req_n = clr_src_sel ? bus_rst_n : por_clr_n;

    // First stage samples the raw request; reset value is inactive.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b1;
        else        chain[0] <= req_n;
    end

    // Remaining stages of the synchroniser chain.
    generate
        for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= 1'b1;
                else        chain[i] <= chain[i-1];
            end
        end
    endgenerate

    // Active-high clear seen by the sequencer.
    always_comb clr_act = ~chain[LAST];
endmodule

// File: rtl/vj_strobe_edge.sv
// Module: detects the end of a bus read, i.e. rd_strobe going from high
// to low between two clock edges. Assumes rd_strobe is synchronous to clk.
module vj_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_strobe,
    output logic strobe_fall
);
    logic strobe_q;

    // Remember the strobe level of the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= rd_strobe;
    end

    // A fall is previous high, current low.
    always_comb strobe_fall = strobe_q & ~rd_strobe;
endmodule

// File: rtl/vj_step_fsm.sv
// Module: five-step sequencer state. The enable has top priority, then a
// synchronised clear (restart at step one), then strobe falls (advance).
// Assumes clr_act and strobe_fall are already in the clock domain.
module vj_step_fsm
    import vj_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     jump_en,
    input  logic     clr_act,
    input  logic     strobe_fall,
    output vj_step_e step
);
    vj_step_e step_nx;

    // Next step from enable, clear and strobe events.
    always_comb begin
        step_nx = step;
        if (!jump_en) begin
            step_nx = ST_IDLE;
        end else if (clr_act) begin
            step_nx = ST_DI;
        end else if (strobe_fall) begin
            unique case (step)
                ST_DI:   step_nx = ST_JMP;
                ST_JMP:  step_nx = ST_LO;
                ST_LO:   step_nx = ST_HI;
                ST_HI:   step_nx = ST_REL;
                ST_REL:  step_nx = ST_IDLE;
                default: step_nx = ST_IDLE;
            endcase
        end
    end

    // Step register.
    always_ff @(posedge clk) begin
        if (!rst_n) step <= ST_IDLE;
        else        step <= step_nx;
    end
endmodule

// File: rtl/vj_byte_mux.sv
// Module: maps the current step to the injected byte and the output
// controls. Assumes tgt_hi is a static setting.
module vj_byte_mux
    import vj_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  vj_step_e        step,
    input  logic [DW-1:0]   tgt_hi,
    input  logic            rd_strobe,
    output logic [DW-1:0]   dout,
    output logic            dout_oe,
    output logic            jump_active,
    output logic            phantom_req
);
    logic byte_step;

    // Byte selection per step; zero outside the four byte steps.
    always_comb begin
        unique case (step)
            ST_DI:   dout = OP_DI;
            ST_JMP:  dout = OP_JMP;
            ST_LO:   dout = OP_LO;
            ST_HI:   dout = tgt_hi;
            default: dout = '0;
        endcase
    end

    // Control outputs derived from the step and the read strobe.
    always_comb begin
        byte_step   = (step == ST_DI) || (step == ST_JMP) ||
                      (step == ST_LO) || (step == ST_HI);
        phantom_req = byte_step;
        jump_active = (step != ST_IDLE);
        dout_oe     = byte_step & rd_strobe;
    end
endmodule

// File: rtl/vecjump_seq.sv
// Module: top of the reset vector jump sequencer. After a synchronised
// clear it injects a disable-interrupts byte and a three-byte jump to
// {tgt_hi, 00} one byte per read strobe, then releases the bus.
// Assumes rd_strobe is synchronous to clk.
module vecjump_seq
    import vj_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_clr_n,
    input  logic              bus_rst_n,
    input  logic              clr_src_sel,
    input  logic              jump_en,
    input  logic [DATA_W-1:0] tgt_hi,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    output logic              jump_active,
    output logic              phantom_req
);
    logic     clr_act;
    logic     strobe_fall;
    vj_step_e step;

    vj_clr_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .por_clr_n(por_clr_n),
        .bus_rst_n(bus_rst_n), .clr_src_sel(clr_src_sel), .clr_act(clr_act)
    );

    vj_strobe_edge u_edge (
        .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .strobe_fall(strobe_fall)
    );

    vj_step_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .jump_en(jump_en), .clr_act(clr_act),
        .strobe_fall(strobe_fall), .step(step)
    );

    vj_byte_mux #(.DW(DATA_W)) u_mux (
        .step(step), .tgt_hi(tgt_hi), .rd_strobe(rd_strobe), .dout(dout),
        .dout_oe(dout_oe), .jump_active(jump_active), .phantom_req(phantom_req)
    );
endmodule

// File: rtl/vecjump_seq_chk.sv
// Module: assertion checker for vecjump_seq, attached by bind. Watches
// only the top-level ports.
module vecjump_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       jump_en,
    input logic       rd_strobe,
    input logic [7:0] tgt_hi,
    input logic [7:0] dout,
    input logic       dout_oe,
    input logic       jump_active,
    input logic       phantom_req
);
    // R6: drive only with the strobe high during a byte step.
    p_oe_needs_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> (rd_strobe && phantom_req));

    // R4: a driven byte is a fixed opcode or the target byte.
    p_driven_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> (dout == 8'hF3 || dout == 8'hC3 || dout == 8'h00 || dout == tgt_hi));

    // R9: phantom request only inside an active sequence.
    p_phantom_in_seq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        phantom_req |-> jump_active);

    // R10: a low enable idles the block on the next edge.
    p_disable_idles_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !jump_en |=> !jump_active);

    // R7: a normal exit passes through the released step.
    p_exit_via_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(jump_active) && $past(jump_en)) |-> !$past(phantom_req));
endmodule

bind vecjump_seq vecjump_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .jump_en(jump_en), .rd_strobe(rd_strobe),
    .tgt_hi(tgt_hi), .dout(dout), .dout_oe(dout_oe),
    .jump_active(jump_active), .phantom_req(phantom_req)
);

// File: tb/tb_vecjump_seq.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random targets and sources.
module tb_vecjump_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       por_clr_n = 1'b1;
    logic       bus_rst_n = 1'b1;
    logic       clr_src_sel = 1'b0;
    logic       jump_en = 1'b1;
    logic [7:0] tgt_hi = 8'h00;
    logic       rd_strobe = 1'b0;
    logic [7:0] dout;
    logic       dout_oe, jump_active, phantom_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    vecjump_seq dut (
        .clk(clk), .rst_n(rst_n), .por_clr_n(por_clr_n), .bus_rst_n(bus_rst_n),
        .clr_src_sel(clr_src_sel), .jump_en(jump_en), .tgt_hi(tgt_hi),
        .rd_strobe(rd_strobe), .dout(dout), .dout_oe(dout_oe),
        .jump_active(jump_active), .phantom_req(phantom_req)
    );

    // Expected byte for step k (0..3) from the requirement R4.
    function automatic logic [7:0] exp_byte(int k, logic [7:0] hi);
        case (k)
            0: return 8'hF3;
            1: return 8'hC3;
            2: return 8'h00;
            default: return hi;
        endcase
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Pulse the selected (or other) clear line, then let the synchroniser settle.
    task automatic pulse_clear(bit use_bus);
        @(negedge clk);
        if (use_bus) bus_rst_n = 1'b0; else por_clr_n = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        bus_rst_n = 1'b1;
        por_clr_n = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    // One read: check the byte while the strobe is high, then end the read.
    task automatic read_byte(logic [7:0] exp, bit exp_oe, string req);
        rd_strobe = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(dout_oe == exp_oe, req, dout_oe, exp_oe);
        if (exp_oe) chk(dout == exp, req, dout, exp);
        @(posedge clk);
        @(negedge clk);
        chk(dout == exp || !exp_oe, "R5 stable", dout, exp);
        rd_strobe = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Full sequence after a clear, with checks on all five steps.
    task automatic run_seq(logic [7:0] hi);
        for (int k = 0; k < 4; k++) begin
            chk(phantom_req == 1'b1, "R9 byte step", phantom_req, 1);
            read_byte(exp_byte(k, hi), 1'b1, "R4 byte");
        end
        chk(jump_active == 1'b1, "R8 fifth step", jump_active, 1);
        chk(phantom_req == 1'b0, "R9 fifth step", phantom_req, 0);
        read_byte(8'h00, 1'b0, "R7 release");
        chk(jump_active == 1'b0, "R7 idle after fifth", jump_active, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(!jump_active && !phantom_req && !dout_oe, "R1 reset", jump_active, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 latency: clear low at a negedge, step one by the third edge.
        clr_src_sel = 1'b0;
        por_clr_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(jump_active && phantom_req, "R3 latency", jump_active, 1);
        // R5: held strobe does not advance during clear hold.
        @(negedge clk);
        por_clr_n = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rd_strobe = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(dout == 8'hF3, "R5 no advance while high", dout, 8'hF3);
        rd_strobe = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(phantom_req == 1'b1, "R5 advance on fall", phantom_req, 1);
        // Now at step two; finish with JMP, LO, HI, release.
        tgt_hi = 8'hA5;
        read_byte(8'hC3, 1'b1, "R5 step two");
        read_byte(8'h00, 1'b1, "R4 low byte");
        read_byte(8'hA5, 1'b1, "R4 high byte");
        read_byte(8'h00, 1'b0, "R7 release");
        chk(jump_active == 1'b0, "R7 idle", jump_active, 0);

        // R2: unselected source ignored.
        clr_src_sel = 1'b1;
        pulse_clear(1'b0);
        chk(jump_active == 1'b0, "R2 unselected por", jump_active, 0);
        pulse_clear(1'b1);
        chk(jump_active == 1'b1, "R2 selected bus", jump_active, 1);
        tgt_hi = 8'hFF;
        run_seq(8'hFF);

        // R3: restart mid-sequence.
        tgt_hi = 8'h01;
        pulse_clear(1'b1);
        read_byte(8'hF3, 1'b1, "R3 first");
        read_byte(8'hC3, 1'b1, "R3 second");
        pulse_clear(1'b1);
        run_seq(8'h01);

        // R10: enable low blocks clear, and drop mid-sequence idles.
        jump_en = 1'b0;
        pulse_clear(1'b1);
        chk(jump_active == 1'b0, "R10 blocked", jump_active, 0);
        jump_en = 1'b1;
        pulse_clear(1'b1);
        read_byte(8'hF3, 1'b1, "R10 pre-drop");
        jump_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(jump_active == 1'b0 && dout == 8'h00, "R10 drop", jump_active, 0);
        jump_en = 1'b1;

        // R6: strobe low during byte step gives no drive.
        pulse_clear(1'b1);
        chk(dout_oe == 1'b0, "R6 no strobe", dout_oe, 0);
        run_seq(8'h01);

        // Random targets and sources.
        for (int n = 0; n < 24; n++) begin
            logic [7:0] hi;
            bit         s;
            hi = 8'($urandom);
            s  = 1'($urandom);
            tgt_hi = hi;
            clr_src_sel = s;
            pulse_clear(s);
            run_seq(hi);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule